// File: doc/BRIEF.md
# External Data Bus Access Sequencer

This block runs one data-memory load or store for the processor core. It takes a request, forms the 16-bit address and decides where the access goes. With the window switched on, the low 1 KB of the space goes to an on-chip data RAM. Every other address, and every address when the window is off, goes to a multiplexed external bus. On that bus the low address byte and the data byte share one set of lines, and a separate high address byte, an address latch pulse and active-low read and write strobes complete it.

Time is counted in states. Four states C1, C2, C3 and C4 make one machine cycle. An external access is stretched to between 2 and 9 machine cycles by a 3-bit stretch input, and the strobe widens with it. A slow peripheral can lengthen the access further, by any number of machine cycles, through an active-low wait pin that passes through a synchroniser. This pin is normally used with a stretch of 0. A single-state done pulse tells the core that the access is finished and, for a load, that the read byte is valid.

The address comes from one of two sources. For a register-indirect access it is the port-2 latch (high byte) joined to the 8-bit pointer (low byte). Otherwise it is the 16-bit data pointer.

Top module: `xmem_seq`

## Requirements
- R1: An external access raises `ale` for exactly the first two states (C1, C2) of its first machine cycle. While `ale` is high, `ad_out` carries the low address byte, `ad_oe` is 1 and `a_hi` carries the high address byte. `a_hi` holds that value for the rest of the access.
- R2: With `req_indirect`=1 the address is {`p2_latch`, `ri_ptr`}. With `req_indirect`=0 it is `dptr`.
- R3: An external access with stretch value S and no wait extension lasts N = S+2 machine cycles. Counting the state after the accepting clock edge as state 1, `done` is high in state 4N+1, which is one state after the strobe returns high.
- R4: The strobe goes low at C1 of the second machine cycle and stays low through C3 of the last one, so it is 4N-5 states wide. `rd_n` is used for loads and `wr_n` for stores, and the two are never low together.
- R5: During a store, `ad_out` carries the write byte with `ad_oe`=1 for every state of the `wr_n` pulse. During a load, `ad_oe` is 0 for every state of the `rd_n` pulse.
- R6: A load returns in `rdata` the value `ad_in` has in the last state in which `rd_n` is low.
- R7: With `ram_en`=1, an address in 0000h–03FFh goes to the internal RAM. `int_req` pulses once with `int_addr` = address bits 9:0 and `int_we` = store. `ale`, `rd_n`, `wr_n`, `ad_oe`, `ad_out` and `a_hi` do not change. `done` is high in state 5, and a load returns `int_rdata`.
- R8: With `ram_en`=0, every address from 0000h to FFFFh, including the low 1 KB, runs as an external access and `int_req` stays low.
- R9: With `ram_en`=1, an address of 0400h or above runs as an external access.
- R10: With `wait_en`=1, the synchronised `wait_n` is sampled at C3 of the last machine cycle. If it is low, one machine cycle is added and the sample is taken again at C3 of the added cycle. There is no limit on the number of added cycles.
- R11: With `wait_en`=0, `wait_n` has no effect on the access length.
- R12: After reset, `ale`=0, `rd_n`=`wr_n`=1, `ad_oe`=0, `busy`=0 and `done`=0. `done` is high for a single state per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock (one period per state) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when `busy` is 0 |
| req_wr | input | 1 | 1 = store, 0 = load |
| req_indirect | input | 1 | 1 = address from pointer byte and port-2 latch |
| ri_ptr | input | 8 | Low address byte for indirect accesses |
| p2_latch | input | 8 | High address byte for indirect accesses |
| dptr | input | 16 | Full address for pointer accesses |
| wdata | input | 8 | Store data |
| stretch | input | 3 | Extra machine cycles beyond two |
| wait_en | input | 1 | Enables the wait pin |
| ram_en | input | 1 | Enables the internal 1 KB window |
| wait_n | input | 1 | Asynchronous active-low wait pin |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-state completion pulse |
| rdata | output | 8 | Load result |
| ale | output | 1 | Address latch enable |
| ad_out | output | 8 | Multiplexed address/data out |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ad_in | input | 8 | Multiplexed data in |
| a_hi | output | 8 | High address byte |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| int_req | output | 1 | Internal RAM access pulse |
| int_we | output | 1 | Internal RAM write enable |
| int_addr | output | 10 | Internal RAM word address |
| int_wdata | output | 8 | Internal RAM write data |
| int_rdata | input | 8 | Internal RAM read data (one clock latency) |

## Verification
The bench builds the block with its defaults: an 8-bit data path, a 3-bit stretch, a 1024-word window, the RAM variant enabled and a two-stage synchroniser. These values cover the full 2-to-9 cycle range and the window edge at 03FFh/0400h. The known two-state synchroniser delay also lets the bench compute exactly how many machine cycles a wait release adds. One access is held for far more cycles than the largest stretch to show that wait insertion has no upper bound.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_EXT  = 2'd1,
      SQ_INT  = 2'd2,
      SQ_DONE = 2'd3
   } sq_state_e;

   // states within one machine cycle; order is behaviour
   localparam logic [1:0] PH_C1 = 2'd0;
   localparam logic [1:0] PH_C2 = 2'd1;
   localparam logic [1:0] PH_C3 = 2'd2;
   localparam logic [1:0] PH_C4 = 2'd3;
endpackage

// File: rtl/xmem_sync.sv
module xmem_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0 || STAGES > 8) begin : g_bad_stages
      $error("xmem_sync: STAGES out of range");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ff <= {STAGES{RST_VAL}};
         end else begin
            ff[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
               ff[i] <= ff[i-1];
            end
         end
      end
      assign q = ff[STAGES-1];
   end
endmodule

// File: rtl/xmem_window.sv
module xmem_window #(
   parameter int ADDR_W    = 16,
   parameter int RAM_WORDS = 1024,
   parameter bit HAS_RAM   = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              ram_en,
   output logic              hit
);
   localparam int RAM_AW = $clog2(RAM_WORDS);

   if ((1 << RAM_AW) != RAM_WORDS) begin : g_bad_pow2
      $error("xmem_window: RAM_WORDS must be a power of two");
   end
   if (RAM_AW >= ADDR_W) begin : g_bad_size
      $error("xmem_window: window must be smaller than the address space");
   end

   if (HAS_RAM) begin : g_ram
      localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(RAM_WORDS);
      assign hit = ram_en && (addr < LIMIT);
   end else begin : g_no_ram
      assign hit = 1'b0;
   end
endmodule

// File: rtl/xmem_phase.sv
module xmem_phase #(
   parameter int MC_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            run,
   input  logic            hold_mc,
   output logic [1:0]      ph,
   output logic [MC_W-1:0] mc
);
   import xmem_pkg::*;

   if (MC_W < 2) begin : g_bad_w
      $error("xmem_phase: MC_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= PH_C1;
         mc <= '0;
      end else if (start) begin
         ph <= PH_C1;
         mc <= '0;
      end else if (run) begin
         ph <= ph + 2'd1;
         if (ph == PH_C4 && !hold_mc) begin
            mc <= mc + MC_W'(1);
         end
      end
   end

   AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> $stable(ph)); // R3
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq #(
   parameter int DATA_W      = 8,
   parameter int STRETCH_W   = 3,
   parameter int RAM_WORDS   = 1024,
   parameter bit HAS_RAM     = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req,
   input  logic                          req_wr,
   input  logic                          req_indirect,
   input  logic [DATA_W-1:0]             ri_ptr,
   input  logic [DATA_W-1:0]             p2_latch,
   input  logic [2*DATA_W-1:0]           dptr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [STRETCH_W-1:0]          stretch,
   input  logic                          wait_en,
   input  logic                          ram_en,
   input  logic                          wait_n,
   output logic                          busy,
   output logic                          done,
   output logic [DATA_W-1:0]             rdata,
   output logic                          ale,
   output logic [DATA_W-1:0]             ad_out,
   output logic                          ad_oe,
   input  logic [DATA_W-1:0]             ad_in,
   output logic [DATA_W-1:0]             a_hi,
   output logic                          rd_n,
   output logic                          wr_n,
   output logic                          int_req,
   output logic                          int_we,
   output logic [$clog2(RAM_WORDS)-1:0]  int_addr,
   output logic [DATA_W-1:0]             int_wdata,
   input  logic [DATA_W-1:0]             int_rdata
);
   import xmem_pkg::*;

   localparam int ADDR_W = 2 * DATA_W;
   localparam int RAM_AW = $clog2(RAM_WORDS);
   localparam int MC_W   = STRETCH_W + 1;

   if (DATA_W < 4) begin : g_bad_data
      $error("xmem_seq: DATA_W too small");
   end
   if (STRETCH_W < 1 || STRETCH_W > 6) begin : g_bad_stretch
      $error("xmem_seq: STRETCH_W out of range");
   end

   sq_state_e            state;
   logic [1:0]           ph;
   logic [MC_W-1:0]      mc;
   logic [MC_W-1:0]      last_mc;
   logic                 wr_q;
   logic                 wen_q;
   logic [DATA_W-1:0]    wdata_q;
   logic                 end_flag;
   logic                 wait_q;
   logic                 hit;
   logic [ADDR_W-1:0]    req_addr;
   logic                 accept;
   logic                 wait_act;
   logic                 is_last;
   logic                 ext_end;
   logic                 run;
   logic                 mc0_c4;

   assign req_addr = req_indirect ? {p2_latch, ri_ptr} : dptr;
   assign accept   = req && (state == SQ_IDLE);
   assign run      = (state == SQ_EXT) || (state == SQ_INT);
   assign is_last  = (mc == last_mc);
   assign wait_act = wen_q && !wait_q;
   assign ext_end  = (state == SQ_EXT) && (ph == PH_C3) && is_last && !wait_act;
   assign mc0_c4   = (state == SQ_EXT) && (mc == '0) && (ph == PH_C4);
   assign busy     = (state != SQ_IDLE);
   assign done     = (state == SQ_DONE);

   xmem_window #(
      .ADDR_W   (ADDR_W),
      .RAM_WORDS(RAM_WORDS),
      .HAS_RAM  (HAS_RAM)
   ) i_window (
      .addr  (req_addr),
      .ram_en(ram_en),
      .hit   (hit)
   );

   xmem_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
   ) i_wait_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (wait_n),
      .q    (wait_q)
   );

   xmem_phase #(
      .MC_W(MC_W)
   ) i_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .run    (run),
      .hold_mc(is_last),
      .ph     (ph),
      .mc     (mc)
   );

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         last_mc  <= '0;
         wr_q     <= 1'b0;
         wen_q    <= 1'b0;
         wdata_q  <= '0;
         end_flag <= 1'b0;
      end else begin
         if (accept) begin
            last_mc  <= {1'b0, stretch} + MC_W'(1);
            wr_q     <= req_wr;
            wen_q    <= wait_en;
            wdata_q  <= wdata;
            end_flag <= 1'b0;
         end else if (ext_end) begin
            end_flag <= 1'b1;
         end
         case (state)
            SQ_IDLE: if (accept) state <= hit ? SQ_INT : SQ_EXT;
            SQ_EXT:  if (ph == PH_C4 && end_flag) state <= SQ_DONE;
            SQ_INT:  if (ph == PH_C4) state <= SQ_DONE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // external bus pins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ale    <= 1'b0;
         ad_out <= '0;
         ad_oe  <= 1'b0;
         a_hi   <= '0;
         rd_n   <= 1'b1;
         wr_n   <= 1'b1;
      end else if (accept && !hit) begin
         ale    <= 1'b1;
         ad_out <= req_addr[DATA_W-1:0];
         ad_oe  <= 1'b1;
         a_hi   <= req_addr[ADDR_W-1:DATA_W];
      end else begin
         if (state == SQ_EXT && mc == '0 && ph == PH_C2) begin
            ale <= 1'b0;
         end
         if (mc0_c4) begin
            ad_oe <= wr_q;
            rd_n  <= wr_q;
            wr_n  <= !wr_q;
            if (wr_q) ad_out <= wdata_q;
         end
         if (ext_end) begin
            rd_n <= 1'b1;
            wr_n <= 1'b1;
         end
         if (state == SQ_EXT && ph == PH_C4 && end_flag) begin
            ad_oe <= 1'b0;
         end
      end
   end

   // internal RAM port and read capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_req   <= 1'b0;
         int_we    <= 1'b0;
         int_addr  <= '0;
         int_wdata <= '0;
         rdata     <= '0;
      end else begin
         int_req <= accept && hit;
         if (accept && hit) begin
            int_we    <= req_wr;
            int_addr  <= req_addr[RAM_AW-1:0];
            int_wdata <= wdata;
         end
         if (ext_end && !wr_q) begin
            rdata <= ad_in;
         end else if (state == SQ_INT && ph == PH_C4 && !wr_q) begin
            rdata <= int_rdata;
         end
      end
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n)); // R4
   AST_STROBE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> (mc != '0 && !ale)); // R4
   AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rd_n) || $rose(wr_n)) |=> done); // R3
   AST_ALE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (mc == '0 && (ph == PH_C1 || ph == PH_C2))); // R1
   AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_INT) |-> (rd_n && wr_n && !ale && !ad_oe && $stable(a_hi))); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12
   AST_HIGH_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_EXT && !(mc == '0 && ph == PH_C1)) |-> $stable(a_hi)); // R1
endmodule

// File: tb/test_xmem_seq.sv
module test_xmem_seq;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      string       tag;
      bit          ext;
      bit          wr;
      logic [15:0] addr;
      logic [7:0]  data;
      int          lat;
      int          strobe;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, req_wr = 1'b0, req_indirect = 1'b0;
   logic [7:0] ri_ptr = '0, p2_latch = '0, wdata = '0;
   logic [15:0] dptr = '0;
   logic [2:0] stretch = '0;
   logic wait_en = 1'b0, ram_en = 1'b0, wait_n = 1'b1;
   logic busy, done, ale, ad_oe, rd_n, wr_n, int_req, int_we;
   logic [7:0] rdata, ad_out, a_hi, int_wdata, ad_in;
   logic [7:0] int_rdata;
   logic [9:0] int_addr;
   logic [7:0] lat_lo = '0;
   logic [7:0] ram_m [0:1023];
   logic [7:0] sb_mem [int];
   exp_t sb[$];
   int n_chk = 0, n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xmem_seq i_xmem_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
      .req_indirect(req_indirect), .ri_ptr(ri_ptr), .p2_latch(p2_latch),
      .dptr(dptr), .wdata(wdata), .stretch(stretch), .wait_en(wait_en),
      .ram_en(ram_en), .wait_n(wait_n), .busy(busy), .done(done),
      .rdata(rdata), .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe),
      .ad_in(ad_in), .a_hi(a_hi), .rd_n(rd_n), .wr_n(wr_n),
      .int_req(int_req), .int_we(int_we), .int_addr(int_addr),
      .int_wdata(int_wdata), .int_rdata(int_rdata)
   );

   function automatic logic [7:0] dev_f(input logic [15:0] a);
      return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
   endfunction

   // external peripheral model
   always @(negedge ale) lat_lo = ad_out;
   assign ad_in = !rd_n ? dev_f({a_hi, lat_lo}) : 8'h00;

   // internal RAM model, one clock read latency
   always @(posedge clk) begin
      if (int_req) begin
         if (int_we) ram_m[int_addr] <= int_wdata;
         int_rdata <= ram_m[int_addr];
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   // monitor
   bit mon_act = 0, post_done = 0;
   int cnt, rd_cnt, wr_cnt, ale_cnt, int_cnt;
   logic [7:0] lo_cap, hi_cap, hi0, ad0, wd_val;
   bit wd_first, wd_bad, oe_bad, touched, hi_moved, iw;
   logic [9:0] ia;

   always @(negedge clk) begin
      if (post_done) begin
         chk("R12 done single state", {31'd0, done}, 32'd0);
         post_done = 0;
      end
      if (!mon_act && req && !busy && rst_n) begin
         mon_act = 1; cnt = 0; rd_cnt = 0; wr_cnt = 0; ale_cnt = 0; int_cnt = 0;
         wd_first = 1; wd_bad = 0; oe_bad = 0; touched = 0; hi_moved = 0;
         hi0 = a_hi; ad0 = ad_out; lo_cap = '0; hi_cap = '0; wd_val = '0; ia = '0; iw = 0;
      end else if (mon_act) begin
         cnt++;
         if (!rd_n) begin rd_cnt++; if (ad_oe) oe_bad = 1; end
         if (!wr_n) begin
            wr_cnt++;
            if (!ad_oe) wd_bad = 1;
            if (wd_first) begin wd_val = ad_out; wd_first = 0; end
            else if (ad_out !== wd_val) wd_bad = 1;
         end
         if (ale) begin ale_cnt++; lo_cap = ad_out; hi_cap = a_hi; end
         else if (ale_cnt == 2 && a_hi !== hi_cap) hi_moved = 1;
         if (ale || !rd_n || !wr_n || ad_oe || a_hi !== hi0 || ad_out !== ad0) touched = 1;
         if (int_req) begin int_cnt++; ia = int_addr; iw = int_we; end
         if (done) begin
            exp_t e;
            mon_act = 0;
            post_done = 1;
            if (sb.size() == 0) begin
               chk("R12 unexpected done", 32'd1, 32'd0);
            end else begin
               e = sb.pop_front();
               chk({"R3 latency ", e.tag}, cnt, e.lat);
               chk({"R4 rd_n width ", e.tag}, rd_cnt, e.wr ? 0 : e.strobe);
               chk({"R4 wr_n width ", e.tag}, wr_cnt, e.wr ? e.strobe : 0);
               if (e.ext) begin
                  chk({"R1 ale states ", e.tag}, ale_cnt, 2);
                  chk({"R2 address ", e.tag}, {16'd0, hi_cap, lo_cap}, {16'd0, e.addr});
                  chk({"R1 high byte held ", e.tag}, {31'd0, hi_moved}, 0);
                  chk({"R8 no internal access ", e.tag}, int_cnt, 0);
                  if (e.wr) chk({"R5 write data ", e.tag}, {23'd0, wd_bad, wd_val}, {24'd0, e.data});
                  else begin
                     chk({"R5 bus released ", e.tag}, {31'd0, oe_bad}, 0);
                     chk({"R6 read data ", e.tag}, {24'd0, rdata}, {24'd0, e.data});
                  end
               end else begin
                  chk({"R7 bus quiet ", e.tag}, {31'd0, touched}, 0);
                  chk({"R7 internal port ", e.tag}, {20'd0, int_cnt[0], iw, ia}, {20'd0, 1'b1, e.wr, e.addr[9:0]});
                  if (!e.wr) chk({"R7 internal read ", e.tag}, {24'd0, rdata}, {24'd0, e.data});
               end
            end
         end
      end
   end

   // driver: rel < 0 keeps wait_n high, otherwise wait_n is low until rel edges after acceptance
   task automatic access(input string tag, input bit wr, input bit ind, input logic [15:0] addr,
                         input logic [7:0] wd, input int s, input bit wen, input bit ren, input int rel);
      exp_t e;
      int ext_mc, n;
      e.tag = tag; e.wr = wr; e.addr = addr;
      e.ext = !(ren && addr < 16'h0400);
      ext_mc = 0;
      if (e.ext && wen && rel > 0) begin
         ext_mc = (rel - 1) / 4 - s;
         if (ext_mc < 0) ext_mc = 0;
      end
      n = s + 2 + ext_mc;
      e.lat    = e.ext ? 4 * n + 1 : 5;
      e.strobe = e.ext ? 4 * n - 5 : 0;
      if (wr) begin
         e.data = wd;
         if (!e.ext) sb_mem[int'(addr[9:0])] = wd;
      end else if (e.ext) e.data = dev_f(addr);
      else e.data = sb_mem.exists(int'(addr[9:0])) ? sb_mem[int'(addr[9:0])] : 8'hxx;
      sb.push_back(e);
      @(posedge clk); #1;
      req_wr = wr; req_indirect = ind; wdata = wd; stretch = 3'(s);
      wait_en = wen; ram_en = ren;
      if (ind) begin p2_latch = addr[15:8]; ri_ptr = addr[7:0]; dptr = ~addr; end
      else begin dptr = addr; p2_latch = ~addr[15:8]; ri_ptr = ~addr[7:0]; end
      wait_n = (rel >= 0) ? 1'b0 : 1'b1;
      req = 1'b1;
      @(posedge clk); #1;
      req = 1'b0;
      if (rel >= 0) begin
         repeat (rel) @(posedge clk);
         #1 wait_n = 1'b1;
      end
      wait (sb.size() == 0);
      repeat (2) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 reset ale", {31'd0, ale}, 0);
      chk("R12 reset strobes", {30'd0, rd_n, wr_n}, 32'd3);
      chk("R12 reset ad_oe", {31'd0, ad_oe}, 0);
      chk("R12 reset busy/done", {30'd0, busy, done}, 0);

      access("R8 direct load s0",          0, 0, 16'h1234, 8'h00, 0, 0, 0, -1);
      access("R2 indirect load s3",        0, 1, 16'hA5C3, 8'h00, 3, 0, 0, -1);
      access("R5 direct store s7",         1, 0, 16'h8001, 8'h5A, 7, 0, 0, -1);
      access("R8 low addr window off",     0, 0, 16'h0010, 8'h00, 1, 0, 0, -1);
      access("R7 store 03FF",              1, 0, 16'h03FF, 8'h77, 4, 0, 1, -1);
      access("R7 load 03FF",               0, 0, 16'h03FF, 8'h00, 4, 0, 1, -1);
      access("R9 load 0400 window on",     0, 0, 16'h0400, 8'h00, 0, 0, 1, -1);
      access("R7 indirect store 0005",     1, 1, 16'h0005, 8'h19, 2, 0, 1, -1);
      access("R7 load 0005",               0, 0, 16'h0005, 8'h00, 0, 0, 1, -1);
      access("R10 wait adds three",        0, 0, 16'h4242, 8'h00, 0, 1, 0, 14);
      access("R10 long wait store",        1, 1, 16'hF00D, 8'hC6, 1, 1, 0, 60);
      access("R11 wait ignored",           0, 0, 16'h7E81, 8'h00, 2, 0, 0, 40);
      access("R10 early release",          0, 0, 16'h2468, 8'h00, 0, 1, 0, 2);
      access("R3 load s5",                 0, 1, 16'hBEEF, 8'h00, 5, 0, 1, -1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule